// File: doc/BRIEF.md
# Fixed-Priority Shared Bus Arbiter

This block decides which of several bus masters may use a single shared system bus. Each master raises its own request line and waits for its own acknowledge line. When the bus is free, the active requests pass through a priority encoder that yields the index of the winner and a valid flag. A decoder then expands that index into a one-hot acknowledge. The lowest-numbered requester always wins, because the priority order is fixed.

The arbiter drives a shared bus-busy line while a master owns the bus. No new grant is issued while that line is high. Requests from other masters wait during that time, including requests from masters of higher priority. The owner keeps its acknowledge for as long as it holds its request. When it drops the request, the bus goes free for one cycle, and the next arbitration happens on the following clock edge.

Top module: `fixed_prio_bus_arbiter`

## Requirements
- R1: During synchronous active-low reset, and on the first cycle after it, every acknowledge bit and the busy line are 0.
- R2: At most one acknowledge bit is 1 in any cycle.
- R3: At a clock edge where busy is 0 and at least one request is 1, the acknowledge becomes one-hot at the lowest set request index (bit 0 is the highest priority, bit NUM_MASTERS-1 the lowest).
- R4: At a clock edge where busy is 0 and no request is 1, the acknowledge stays all zeros.
- R5: While busy is 1, requests from masters other than the owner have no effect on the acknowledge. This holds even for masters of higher priority.
- R6: The owner keeps its acknowledge bit at 1 across every edge at which its own request is still 1.
- R7: At the first edge at which the owner's request is 0, the acknowledge clears and busy falls. A new grant can come no earlier than the edge after that.
- R8: Busy is 1 exactly when some acknowledge bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_MASTERS | Request line per master; bit 0 has the highest priority |
| ack_o | output | NUM_MASTERS | Registered one-hot acknowledge per master |
| busy_o | output | 1 | Shared bus-busy line; high while a master owns the bus |

## Verification
Every result is registered, so the acknowledge and busy values that follow a request pattern appear one rising edge after that pattern is applied. A release shows up in the same way: the edge that sees the dropped request clears the outputs, and a waiting requester is granted one edge later. The driver applies each pattern on a falling edge and queues the expected acknowledge and busy values for the next rising edge. The monitor compares them a quarter period after that rising edge, so each queued entry matches exactly one edge.

// File: rtl/arb_pkg.sv
// Package: shared types for the fixed-priority bus arbiter.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package arb_pkg;
    // Ownership state of the shared bus.
    typedef enum logic {
        BUS_FREE  = 1'b0,
        BUS_OWNED = 1'b1
    } bus_state_e;
endpackage

// File: rtl/arb_prio_encoder.sv
// Module: arb_prio_encoder
// Turns a request vector into the index of the lowest set bit plus a valid flag.
// Assumes: N >= 2; bit 0 has the highest priority. Purely combinational.
module arb_prio_encoder #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    logic [N:0]   masked;   // masked[i]: some request below index i is set
    logic [N-1:0] sel;      // one-hot winner

    assign masked[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chain
            // Winner chain: bit wins when set and nothing lower is set.
            assign sel[gi]        = req_i[gi] & ~masked[gi];
            assign masked[gi + 1] = masked[gi] | req_i[gi];
        end
    endgenerate

    // Binary-encode the winner position.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign valid_o = masked[N];
endmodule

// File: rtl/arb_onehot_decoder.sv
// Module: arb_onehot_decoder
// Expands a binary index into a one-hot vector, gated by a valid flag.
// Assumes: index below N when valid. Purely combinational.
module arb_onehot_decoder #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             valid_i,
    output logic [N-1:0]     onehot_o
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_dec
            // Output line gi matches its own index only when valid.
            assign onehot_o[gi] = valid_i && (idx_i == IDX_W'(gi));
        end
    endgenerate
endmodule

// File: rtl/arb_owner_ctrl.sv
// Module: arb_owner_ctrl
// Holds the bus owner: accepts a candidate grant only while the bus is free,
// keeps it while the owner requests, and frees the bus on release.
// Assumes: cand_i is one-hot or zero; synchronous active-low reset.
module arb_owner_ctrl
    import arb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] ack_o,
    output logic         busy_o
);
    bus_state_e   state_q;
    logic [N-1:0] ack_q;
    logic         owner_holds;

    assign owner_holds = |(ack_q & req_i);

    // Ownership register: grant when free, hold while requested, release after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_FREE;
            ack_q   <= '0;
        end else if (state_q == BUS_OWNED) begin
            if (!owner_holds) begin
                state_q <= BUS_FREE;
                ack_q   <= '0;
            end
        end else if (|cand_i) begin
            state_q <= BUS_OWNED;
            ack_q   <= cand_i;
        end
    end

    assign ack_o  = ack_q;
    assign busy_o = (state_q == BUS_OWNED);

    // R2: never more than one acknowledge
    a_r2_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    // R5, R6: while the owner still requests, the acknowledge is unchanged
    a_r6_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && |(ack_o & req_i)) |=> $stable(ack_o));

    // R7: owner release frees the bus at the next edge
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(|(ack_o & req_i))) |=> (!busy_o && ack_o == '0));

    // R8: busy tracks the presence of an acknowledge
    a_r8_busy_match: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (|ack_o));
endmodule

// File: rtl/fixed_prio_bus_arbiter.sv
// Module: fixed_prio_bus_arbiter (top)
// Fixed-priority arbiter for a shared bus: priority encode, decode to one-hot,
// register as the acknowledge, gated by the shared busy line.
// Assumes: NUM_MASTERS >= 2; request bit 0 is the highest priority.
module fixed_prio_bus_arbiter #(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_i,
    output logic [NUM_MASTERS-1:0] ack_o,
    output logic                   busy_o
);
    localparam int IDX_W = $clog2(NUM_MASTERS);

    logic [IDX_W-1:0]       win_idx;
    logic                   win_valid;
    logic [NUM_MASTERS-1:0] cand;

    arb_prio_encoder #(.N(NUM_MASTERS), .IDX_W(IDX_W)) enc_i (
        .req_i   (req_i),
        .idx_o   (win_idx),
        .valid_o (win_valid)
    );

    arb_onehot_decoder #(.N(NUM_MASTERS), .IDX_W(IDX_W)) dec_i (
        .idx_i    (win_idx),
        .valid_i  (win_valid),
        .onehot_o (cand)
    );

    arb_owner_ctrl #(.N(NUM_MASTERS)) own_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .cand_i (cand),
        .ack_o  (ack_o),
        .busy_o (busy_o)
    );

    // R3: a free bus with the top-priority request grants master 0
    a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i[0]) |=> ack_o[0]);

    // R4: a free bus with no requests stays idle
    a_r4_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i == '0) |=> (ack_o == '0 && !busy_o));

    // R5: while owned, an outsider's request does not take the bus
    a_r5_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ack_o[0] && req_i[0]) |=> !ack_o[0]);
endmodule

// File: tb/fixed_prio_bus_arbiter_tb_top.sv
// Scoreboard bench: the driver queues the expected outputs per applied pattern,
// and the monitor compares them a quarter period after the next rising edge.
module fixed_prio_bus_arbiter_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] ack;
    logic         busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        logic [N-1:0] exp_ack;
        logic         exp_busy;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    logic [N-1:0] model_ack = '0;

    fixed_prio_bus_arbiter #(.NUM_MASTERS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_o(ack), .busy_o(busy)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Apply a request pattern and queue the result expected at the next edge.
    task automatic apply(input logic [N-1:0] r, input string tag);
        exp_t e;
        @(negedge clk);
        req = r;
        if (model_ack != '0) begin
            if ((model_ack & r) == '0) model_ack = '0;
        end else begin
            model_ack = r & (~r + 1'b1);
        end
        e.exp_ack  = model_ack;
        e.exp_busy = (model_ack != '0);
        e.tag      = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare one queued entry per rising edge.
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (ack !== e.exp_ack || busy !== e.exp_busy) begin
                fails++;
                $display("FAIL %s: ack=%b busy=%b expected ack=%b busy=%b",
                         e.tag, ack, busy, e.exp_ack, e.exp_busy);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs are low while in reset, even with every request set.
        req = '1;
        repeat (3) @(negedge clk);
        checks++;
        if (ack !== '0 || busy !== 1'b0) begin
            fails++;
            $display("FAIL R1: ack=%b busy=%b expected ack=0000 busy=0", ack, busy);
        end
        req = '0;
        rst_n = 1'b1;
        apply(4'b0000, "R1 first cycle after reset");
        apply(4'b0000, "R4 idle, no requests");
        apply(4'b0000, "R4 idle again");
        apply(4'b1000, "R3 single lowest-priority request");
        apply(4'b1001, "R5 higher request while owned");
        apply(4'b1111, "R6 owner still requesting");
        apply(4'b0111, "R7 owner drops, bus frees");
        apply(4'b0111, "R3 regrant lowest index after free");
        apply(4'b0110, "R7 master 0 releases");
        apply(4'b0110, "R3 master 1 wins over 2");
        apply(4'b0110, "R6 master 1 holds");
        apply(4'b0100, "R7 master 1 releases");
        apply(4'b0100, "R3 master 2 granted");
        apply(4'b0101, "R5 master 0 cannot preempt");
        apply(4'b0001, "R7 master 2 releases, 0 waits");
        apply(4'b0001, "R2 R8 single grant to master 0");
        apply(4'b0000, "R7 master 0 releases");
        apply(4'b1100, "R3 master 2 over 3");
        apply(4'b0000, "R7 release to idle");
        apply(4'b0000, "R4 idle stays zero");
        for (int k = 1; k < 16; k++) begin
            apply(N'(k), "R3 R6 sweep pattern");
            apply(N'(k), "R6 R8 sweep hold");
            apply('0,    "R7 sweep release");
        end
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule